// File: doc/BRIEF.md
# Multi-Channel Conversion Sequencer

This block drives an analog-to-digital converter through a list of positive input channels for every start request. A 32-bit enable mask chooses the channels. One start pulse converts each enabled channel once, from the lowest index to the highest. After each conversion the next channel starts without any further request. The negative-input selection is captured when the scan begins and does not change until the scan ends. If the mask is all zeros, the block does a single conversion on a default channel instead.

For each conversion the block sets the channel selects and issues a one-cycle start pulse to the converter. It then waits for the converter's done strobe. On that strobe it latches the result and the number of the channel just converted, and it raises a result-ready flag. That flag stays set until a write-one-to-clear input clears it. A busy output covers the whole scan. The enable mask, the default channel and the negative select are captured in the cycle the scan is accepted, so changes to them during a scan have no effect on it.

Top module: `conv_scan_seq`

## Requirements
- R1: After reset, `busy`, `conv_start` and `res_ready` are 0.
- R2: A `start_req` sampled while idle with a non-zero mask sets `busy` and pulses `conv_start` for one cycle on the next clock edge, with `pos_sel` equal to the lowest set bit index of `chan_mask`.
- R3: Within a scan, every channel whose mask bit is 1 is converted exactly once, in strictly ascending index order.
- R4: A `conv_done` that is not the scan's last causes `conv_start` to pulse at the same clock edge, on the next enabled channel.
- R5: `busy` falls at the clock edge that samples the `conv_done` of the last enabled channel.
- R6: At each clock edge that samples `conv_done` during a scan, `result` takes `conv_data`, `last_chan` takes the channel just converted, and `res_ready` becomes 1.
- R7: `neg_sel` equals the `neg_sel_in` value sampled with the accepted start and holds that value for the whole scan.
- R8: A scan started with an all-zero mask does exactly one conversion, on the channel `dflt_chan` gave at the start.
- R9: `start_req` while `busy` is 1 is ignored: it neither restarts nor extends the scan.
- R10: `res_ready` stays 1 until a cycle with `rdy_clr` = 1 clears it. When `rdy_clr` and a completing `conv_done` fall in the same cycle, the set wins.
- R11: Changes to `chan_mask`, `dflt_chan` or `neg_sel_in` after the start is accepted do not alter the running scan.
- R12: `conv_done` while idle leaves `result`, `last_chan` and `busy` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chan_mask | input | NUM_CH (32) | Enable bit per positive channel |
| dflt_chan | input | CH_W (5) | Channel converted when the mask is empty |
| neg_sel_in | input | NEG_W (5) | Negative-input selection for the next scan |
| start_req | input | 1 | Request to start a scan |
| conv_done | input | 1 | Converter finished one conversion |
| conv_data | input | RES_W (16) | Converter result, valid with `conv_done` |
| rdy_clr | input | 1 | Write-one-to-clear for `res_ready` |
| pos_sel | output | CH_W (5) | Positive channel being converted |
| neg_sel | output | NEG_W (5) | Negative selection for the scan |
| conv_start | output | 1 | One-cycle start pulse to the converter |
| busy | output | 1 | Scan in progress |
| last_chan | output | CH_W (5) | Channel of the last completed conversion |
| result | output | RES_W (16) | Latched conversion result |
| res_ready | output | 1 | New result available |

## Verification
The assertions assume the converter raises `conv_done` at most once after each `conv_start`, and never in the same cycle as that start pulse. They also assume `start_req` is low while reset is asserted. The bench's converter model waits for each start pulse and then waits at least one more cycle before it strobes done. It sends idle-time done strobes only after the scan has ended. The sweeps cover every single-channel mask, empty masks with a range of default channels, the full mask and pseudo-random masks. Some runs change the inputs in the middle of a scan and send repeated start requests.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;
  typedef enum logic [0:0] {
    SQ_IDLE = 1'b0,
    SQ_WAIT = 1'b1
  } sq_state_e;
endpackage

// File: rtl/scan_pick.sv
// Priority search: lowest set bit of the mask, either over the whole mask
// (from_base = 1) or only over bits strictly above cur.
module scan_pick #(
  parameter int NUM_CH = 32,
  parameter int CH_W   = $clog2(NUM_CH)
) (
  input  logic [NUM_CH-1:0] mask,
  input  logic [CH_W-1:0]   cur,
  input  logic              from_base,
  output logic              found,
  output logic [CH_W-1:0]   idx
);
  logic [NUM_CH-1:0] cand;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_cand
    assign cand[g] = mask[g] & (from_base | (g > int'(cur)));
  end

  function automatic logic [CH_W:0] lowest_set(input logic [NUM_CH-1:0] v);
    logic [CH_W:0] r;
    r = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (v[i]) r = {1'b1, CH_W'(i)};
    end
    return r;
  endfunction

  assign {found, idx} = lowest_set(cand);
endmodule

// File: rtl/scan_ctrl.sv
module scan_ctrl
  import scan_seq_pkg::*;
#(
  parameter int NUM_CH = 32,
  parameter int CH_W   = $clog2(NUM_CH),
  parameter int NEG_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] chan_mask,
  input  logic [CH_W-1:0]   dflt_chan,
  input  logic [NEG_W-1:0]  neg_sel_in,
  input  logic              start_req,
  input  logic              conv_done,
  output logic [CH_W-1:0]   pos_sel,
  output logic [NEG_W-1:0]  neg_sel,
  output logic              conv_start,
  output logic              busy,
  output logic              seq_start_ev,
  output logic              conv_fin_ev,
  output logic              seq_end_ev
);
  sq_state_e         state;
  logic [NUM_CH-1:0] mask_q;
  logic              first_found, nxt_found;
  logic [CH_W-1:0]   first_idx, nxt_idx;

  scan_pick #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_first (
    .mask(chan_mask), .cur('0), .from_base(1'b1),
    .found(first_found), .idx(first_idx)
  );

  scan_pick #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_next (
    .mask(mask_q), .cur(pos_sel), .from_base(1'b0),
    .found(nxt_found), .idx(nxt_idx)
  );

  assign busy         = (state == SQ_WAIT);
  assign seq_start_ev = (state == SQ_IDLE) && start_req;
  assign conv_fin_ev  = (state == SQ_WAIT) && conv_done;
  assign seq_end_ev   = conv_fin_ev && !nxt_found;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= SQ_IDLE;
      mask_q     <= '0;
      pos_sel    <= '0;
      neg_sel    <= '0;
      conv_start <= 1'b0;
    end else begin
      conv_start <= 1'b0;
      unique case (state)
        SQ_IDLE: begin
          if (seq_start_ev) begin
            mask_q     <= chan_mask;
            neg_sel    <= neg_sel_in;
            pos_sel    <= first_found ? first_idx : dflt_chan;
            conv_start <= 1'b1;
            state      <= SQ_WAIT;
          end
        end
        SQ_WAIT: begin
          if (conv_fin_ev) begin
            if (nxt_found) begin
              pos_sel    <= nxt_idx;
              conv_start <= 1'b1;
            end else begin
              state <= SQ_IDLE;
            end
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/result_latch.sv
module result_latch #(
  parameter int CH_W  = 5,
  parameter int RES_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             conv_fin_ev,
  input  logic [RES_W-1:0] conv_data,
  input  logic [CH_W-1:0]  cur_chan,
  input  logic             rdy_clr,
  output logic [RES_W-1:0] result,
  output logic [CH_W-1:0]  last_chan,
  output logic             res_ready
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result    <= '0;
      last_chan <= '0;
      res_ready <= 1'b0;
    end else begin
      if (conv_fin_ev) begin
        result    <= conv_data;
        last_chan <= cur_chan;
        res_ready <= 1'b1;
      end else if (rdy_clr) begin
        res_ready <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/conv_scan_seq.sv
module conv_scan_seq #(
  parameter int NUM_CH = 32,
  parameter int CH_W   = $clog2(NUM_CH),
  parameter int NEG_W  = 5,
  parameter int RES_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] chan_mask,
  input  logic [CH_W-1:0]   dflt_chan,
  input  logic [NEG_W-1:0]  neg_sel_in,
  input  logic              start_req,
  input  logic              conv_done,
  input  logic [RES_W-1:0]  conv_data,
  input  logic              rdy_clr,
  output logic [CH_W-1:0]   pos_sel,
  output logic [NEG_W-1:0]  neg_sel,
  output logic              conv_start,
  output logic              busy,
  output logic [CH_W-1:0]   last_chan,
  output logic [RES_W-1:0]  result,
  output logic              res_ready
);
  logic seq_start_ev;
  logic conv_fin_ev;
  logic seq_end_ev;

  scan_ctrl #(.NUM_CH(NUM_CH), .CH_W(CH_W), .NEG_W(NEG_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .chan_mask(chan_mask), .dflt_chan(dflt_chan),
    .neg_sel_in(neg_sel_in), .start_req(start_req), .conv_done(conv_done),
    .pos_sel(pos_sel), .neg_sel(neg_sel), .conv_start(conv_start),
    .busy(busy), .seq_start_ev(seq_start_ev), .conv_fin_ev(conv_fin_ev),
    .seq_end_ev(seq_end_ev)
  );

  result_latch #(.CH_W(CH_W), .RES_W(RES_W)) u_res (
    .clk(clk), .rst_n(rst_n), .conv_fin_ev(conv_fin_ev),
    .conv_data(conv_data), .cur_chan(pos_sel), .rdy_clr(rdy_clr),
    .result(result), .last_chan(last_chan), .res_ready(res_ready)
  );
endmodule

// File: rtl/conv_scan_seq_chk.sv
module conv_scan_seq_chk #(
  parameter int CH_W  = 5,
  parameter int NEG_W = 5,
  parameter int RES_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_req,
  input logic             conv_done,
  input logic [CH_W-1:0]  pos_sel,
  input logic [NEG_W-1:0] neg_sel,
  input logic             conv_start,
  input logic             busy,
  input logic [CH_W-1:0]  last_chan,
  input logic [RES_W-1:0] result,
  input logic             res_ready,
  input logic             conv_fin_ev,
  input logic             seq_end_ev
);
  // R2
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start_req));

  // R4
  start_in_scan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> busy);

  // R7
  neg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(neg_sel));

  // R6
  ready_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_fin_ev |=> res_ready && (last_chan == $past(pos_sel)));

  // R3
  ascend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start && $past(busy) |-> pos_sel > last_chan);

  // R9
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start_req && !conv_done |=> $stable(pos_sel) && !conv_start);

  // R12
  idle_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !start_req && conv_done |=> $stable(result) && $stable(last_chan) && !busy);

  // R5
  scan_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_end_ev |=> !busy && !conv_start);
endmodule

bind conv_scan_seq conv_scan_seq_chk #(.CH_W(CH_W), .NEG_W(NEG_W), .RES_W(RES_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_req(start_req), .conv_done(conv_done),
  .pos_sel(pos_sel), .neg_sel(neg_sel), .conv_start(conv_start), .busy(busy),
  .last_chan(last_chan), .result(result), .res_ready(res_ready),
  .conv_fin_ev(conv_fin_ev), .seq_end_ev(seq_end_ev)
);

// File: tb/conv_scan_seq_tb.sv
module conv_scan_seq_tb;
  localparam int NUM_CH = 32;
  localparam int CH_W   = 5;
  localparam int NEG_W  = 5;
  localparam int RES_W  = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NUM_CH-1:0] chan_mask = '0;
  logic [CH_W-1:0]   dflt_chan = '0;
  logic [NEG_W-1:0]  neg_sel_in = '0;
  logic              start_req = 1'b0;
  logic              conv_done = 1'b0;
  logic [RES_W-1:0]  conv_data = '0;
  logic              rdy_clr = 1'b0;
  logic [CH_W-1:0]   pos_sel;
  logic [NEG_W-1:0]  neg_sel;
  logic              conv_start;
  logic              busy;
  logic [CH_W-1:0]   last_chan;
  logic [RES_W-1:0]  result;
  logic              res_ready;

  int checks = 0;
  int errors = 0;
  int seq_id = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  conv_scan_seq #(.NUM_CH(NUM_CH), .CH_W(CH_W), .NEG_W(NEG_W), .RES_W(RES_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .chan_mask(chan_mask), .dflt_chan(dflt_chan),
    .neg_sel_in(neg_sel_in), .start_req(start_req), .conv_done(conv_done),
    .conv_data(conv_data), .rdy_clr(rdy_clr), .pos_sel(pos_sel),
    .neg_sel(neg_sel), .conv_start(conv_start), .busy(busy),
    .last_chan(last_chan), .result(result), .res_ready(res_ready)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [RES_W-1:0] sample_val(input int ch, input int id);
    return RES_W'((ch * 37 + id * 11) ^ 16'hA5C3);
  endfunction

  task automatic run_seq(input logic [NUM_CH-1:0] mask, input int dflt, input int neg,
                         input int delay, input bit alt_mid, input bit poke,
                         input bit clr_with_done);
    int exp_ch[NUM_CH];
    int n;
    logic [RES_W-1:0] d;
    string ord_tag;
    n = 0;
    if (mask == '0) begin
      exp_ch[0] = dflt;
      n = 1;
    end else begin
      for (int i = 0; i < NUM_CH; i++) if (mask[i]) begin exp_ch[n] = i; n++; end
    end
    ord_tag = (mask == '0) ? "R8" : (alt_mid ? "R11" : "R3");
    seq_id++;
    @(negedge clk);
    chan_mask = mask; dflt_chan = CH_W'(dflt); neg_sel_in = NEG_W'(neg); start_req = 1'b1;
    @(negedge clk);
    start_req = 1'b0;
    if (alt_mid) begin
      chan_mask = ~mask; dflt_chan = ~CH_W'(dflt); neg_sel_in = ~NEG_W'(neg);
    end
    d = '0;
    for (int k = 0; k < n; k++) begin
      check(conv_start == 1'b1, (k == 0) ? "R2 start pulse" : "R4 auto start", conv_start, 1);
      check(pos_sel == CH_W'(exp_ch[k]), ord_tag, pos_sel, exp_ch[k]);
      check(neg_sel == NEG_W'(neg), "R7 neg hold", neg_sel, neg);
      check(busy == 1'b1, "R2 busy", busy, 1);
      rdy_clr = 1'b1;
      start_req = poke;
      @(negedge clk);
      rdy_clr = 1'b0;
      start_req = 1'b0;
      check(res_ready == 1'b0, "R10 clear", res_ready, 0);
      check(conv_start == 1'b0, poke ? "R9 ignored start" : "R2 one-cycle pulse", conv_start, 0);
      repeat (delay) @(negedge clk);
      d = sample_val(exp_ch[k], seq_id);
      conv_done = 1'b1; conv_data = d; rdy_clr = clr_with_done;
      @(negedge clk);
      conv_done = 1'b0; rdy_clr = 1'b0;
      check(result == d, "R6 result", result, d);
      check(last_chan == CH_W'(exp_ch[k]), "R6 last_chan", last_chan, exp_ch[k]);
      check(res_ready == 1'b1, clr_with_done ? "R10 set wins" : "R6 ready", res_ready, 1);
      if (k == n - 1) begin
        check(busy == 1'b0, "R5 busy falls", busy, 0);
        check(conv_start == 1'b0, "R5 no more starts", conv_start, 0);
      end
    end
    @(negedge clk);
    check(busy == 1'b0, "R9 no restart", busy, 0);
    conv_done = 1'b1; conv_data = ~d;
    @(negedge clk);
    conv_done = 1'b0;
    check(result == d, "R12 idle done result", result, d);
    check(last_chan == CH_W'(exp_ch[n-1]), "R12 idle done chan", last_chan, exp_ch[n-1]);
    check(busy == 1'b0, "R12 idle done busy", busy, 0);
    check(res_ready == 1'b1, "R10 held", res_ready, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [NUM_CH-1:0] lfsr;
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R1 busy", busy, 0);
    check(conv_start == 1'b0, "R1 conv_start", conv_start, 0);
    check(res_ready == 1'b0, "R1 res_ready", res_ready, 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NUM_CH; i++)
      run_seq(NUM_CH'(1) << i, (i * 7) % NUM_CH, i % 32, i % 3, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 8; i++)
      run_seq('0, i * 4 + 3, 31 - i, 1, i[0], i[1], i[2]);
    run_seq('1, 0, 9, 0, 1'b0, 1'b1, 1'b0);
    run_seq('1, 5, 22, 1, 1'b1, 1'b0, 1'b1);
    lfsr = 32'hACE1_1357;
    for (int i = 0; i < 24; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      run_seq(lfsr, i, i + 1, i % 4, i[1], i[0], i[2]);
    end
    @(negedge clk);
    rdy_clr = 1'b1;
    @(negedge clk);
    rdy_clr = 1'b0;
    check(res_ready == 1'b0, "R10 final clear", res_ready, 0);
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule